// File: doc/BRIEF.md
# Snooping Write-Invalidate Coherence Controller

This block keeps a set of small private write-back caches, one per core, coherent over a single shared broadcast bus placed in front of a shared memory. Every cache watches every bus transaction, not only its own. Each cache line is invalid, shared or modified. A core that wants to write first gains sole ownership by broadcasting an invalidate, and only then updates its copy. When a read misses on a line that a peer holds dirty, the peer supplies the data instead of memory and writes it back in the same step.

Each core drives a load/store request port with a valid/ready handshake. Once `core_req_valid` is high, the core must hold the address, direction and store data unchanged until `core_req_ready` is high. That ready cycle completes the operation, and for a load `core_rsp_rdata` carries the result in that same cycle. There is no back-pressure on the response: a core must take the data in the ready cycle. A round-robin arbiter grants the bus to one cache per transaction, and each transaction runs to completion before the next grant. Memory is a fixed-latency port: a read issued in one cycle returns its data in the next cycle, and a write takes effect at the clock edge.

Lines are one data word wide and each cache is direct-mapped. A store miss therefore never needs the old memory contents.

Top module: `coh_snoop_fabric`

## Requirements
- R1: Every load returns the value of the most recent store to that address, where stores are ordered by their completion cycle across all cores.
- R2: A load to a line held shared or modified, or a store to a line held modified, completes in the cycle it is presented, with no memory access. In a cycle that completes a bus transaction, local hits wait, so at most one request completes in that cycle.
- R3: A store to a line the cache holds shared goes to the bus as an invalidate-only upgrade. It does not complete in its first cycle, and memory is neither read nor written for it.
- R4: A read miss to a line that a peer holds modified is served by that peer without a memory read. Memory is written with the supplied value during the same transaction.
- R5: After supplying a line for a read, the former owner keeps it shared, so its next load of that address hits in the cycle it is presented.
- R6: A store by one core invalidates every peer copy. A peer's next load of that address does not complete in its first cycle, and it returns the stored value.
- R7: When a modified line is displaced by a miss to another address with the same line index, its value is written to memory before the new line is filled.
- R8: At any time at most one cache holds a given address modified.
- R9: At most one cache holds the bus grant, and grants are issued only while the bus is idle. Grants rotate, so simultaneous requesters complete in distinct cycles.
- R10: `core_req_ready` is high only while `core_req_valid` is high. A pending request that the core holds stable stays pending until it is completed.
- R11: A memory read and a memory write are never issued in the same cycle.
- R12: After reset every line is invalid. Ready and both memory enables stay low while no request is pending, and the first access to any address goes to memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_req_valid | input | NCORE | Per-core request valid |
| core_req_ready | output | NCORE | Per-core completion; the handshake cycle |
| core_req_write | input | NCORE | Per-core direction, 1 = store |
| core_req_addr | input | NCORE*AW | Per-core word address, core c at bits c*AW upward |
| core_req_wdata | input | NCORE*DW | Per-core store data |
| core_rsp_rdata | output | NCORE*DW | Per-core load data, valid in the ready cycle |
| mem_rd_en | output | 1 | Memory read request |
| mem_wr_en | output | 1 | Memory write request |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle after mem_rd_en |

## Verification
The hardest situation to reach from the ports is a cache that decided to upgrade a shared line but loses that copy to a peer's invalidate before its own grant arrives. The design must then fall back to a full read-for-ownership, and any stale data must not leak into a load. To reach it, three cores issue random loads and stores with random idle gaps over a pool of twelve addresses that share four line indices. Contention, upgrades racing each other, owner supply and dirty evictions therefore recur many times. Directed sequences first walk one address through every state transition, with a single core active at a time, so that latency and memory traffic can be attributed exactly.

// File: rtl/coh_pkg.sv
`timescale 1ns/1ps
package coh_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'b00,
    LS_SHR = 2'b01,
    LS_MOD = 2'b10
  } line_st_e;

  typedef enum logic [1:0] {
    BC_RD  = 2'b00,
    BC_RDX = 2'b01,
    BC_UPG = 2'b10
  } bus_cmd_e;

  typedef enum logic [1:0] {
    BS_IDLE,
    BS_WB,
    BS_XFER,
    BS_WAIT
  } bus_st_e;
endpackage

// File: rtl/coh_rr_arb.sv
`timescale 1ns/1ps
module coh_rr_arb #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] ptr;
  logic [PW-1:0] win;
  logic          found;

  always_comb begin
    logic [PW:0] s;
    gnt   = '0;
    win   = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      s = {1'b0, ptr} + (PW+1)'(k);
      if (s >= (PW+1)'(N)) s = s - (PW+1)'(N);
      if (en && !found && req[s[PW-1:0]]) begin
        gnt[s[PW-1:0]] = 1'b1;
        win            = s[PW-1:0];
        found          = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else if (found) ptr <= (win == PW'(N-1)) ? '0 : win + 1'b1;
  end
endmodule

// File: rtl/coh_cache.sv
`timescale 1ns/1ps
module coh_cache
  import coh_pkg::*;
#(
  parameter int AW   = 8,
  parameter int DW   = 16,
  parameter int IDXW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic [DW-1:0] rsp_rdata,
  output logic          bus_req,
  output bus_cmd_e      bus_req_cmd,
  output logic          vic_dirty,
  output logic [AW-1:0] vic_addr,
  output logic [DW-1:0] vic_data,
  input  logic          bus_done,
  input  logic          bus_src,
  input  bus_cmd_e      bus_cmd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] fill_data,
  output logic          snp_dirty,
  output logic [DW-1:0] snp_data
);
  localparam int NL = 1 << IDXW;
  localparam int TW = AW - IDXW;

  line_st_e      st [NL];
  logic [TW-1:0] tg [NL];
  logic [DW-1:0] dt [NL];

  logic [IDXW-1:0] r_idx, s_idx;
  logic [TW-1:0]   r_tag, s_tag;
  logic            hit, can_local, loc_ok, s_match, own_done;

  assign r_idx = req_addr[IDXW-1:0];
  assign r_tag = req_addr[AW-1:IDXW];
  assign s_idx = bus_addr[IDXW-1:0];
  assign s_tag = bus_addr[AW-1:IDXW];

  assign hit       = (st[r_idx] != LS_INV) && (tg[r_idx] == r_tag);
  assign can_local = hit && (!req_write || st[r_idx] == LS_MOD);
  assign loc_ok    = req_valid && can_local && !bus_done;
  assign own_done  = bus_done && bus_src;

  assign req_ready = loc_ok || own_done;
  assign rsp_rdata = own_done ? fill_data : dt[r_idx];

  assign bus_req     = req_valid && !can_local;
  assign bus_req_cmd = (hit && req_write) ? BC_UPG : (req_write ? BC_RDX : BC_RD);
  assign vic_dirty   = (st[r_idx] == LS_MOD) && !hit;
  assign vic_addr    = {tg[r_idx], r_idx};
  assign vic_data    = dt[r_idx];

  assign s_match   = (st[s_idx] != LS_INV) && (tg[s_idx] == s_tag);
  assign snp_dirty = s_match && (st[s_idx] == LS_MOD);
  assign snp_data  = dt[s_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NL; i++) st[i] <= LS_INV;
    end else if (bus_done) begin
      if (bus_src) begin
        st[s_idx] <= (bus_cmd == BC_RD) ? LS_SHR : LS_MOD;
      end else if (s_match) begin
        if (bus_cmd == BC_RD) begin
          if (st[s_idx] == LS_MOD) st[s_idx] <= LS_SHR;
        end else begin
          st[s_idx] <= LS_INV;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (own_done) begin
      tg[s_idx] <= s_tag;
      dt[s_idx] <= (bus_cmd == BC_RD) ? fill_data : req_wdata;
    end else if (loc_ok && req_write) begin
      dt[r_idx] <= req_wdata;
    end
  end
endmodule

// File: rtl/coh_bus_ctrl.sv
`timescale 1ns/1ps
module coh_bus_ctrl
  import coh_pkg::*;
#(
  parameter int N  = 3,
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  gnt,
  input  bus_cmd_e      req_cmd   [N],
  input  logic [AW-1:0] req_addr  [N],
  input  logic [N-1:0]  vic_dirty,
  input  logic [AW-1:0] vic_addr  [N],
  input  logic [DW-1:0] vic_data  [N],
  input  logic [N-1:0]  snp_dirty,
  input  logic [DW-1:0] snp_data  [N],
  output logic          idle,
  output logic          done,
  output logic [N-1:0]  src_oh,
  output bus_cmd_e      cmd,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] fill,
  output logic          mem_rd_en,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  bus_st_e       st;
  logic [AW-1:0] v_addr;
  logic [DW-1:0] v_data;

  bus_cmd_e      w_cmd;
  logic [AW-1:0] w_addr, w_vaddr;
  logic [DW-1:0] w_vdata, own_data;
  logic          w_vdirty, own_hit;

  always_comb begin
    w_cmd = BC_RD; w_addr = '0; w_vaddr = '0; w_vdata = '0; w_vdirty = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (gnt[i]) begin
        w_cmd    = req_cmd[i];
        w_addr   = req_addr[i];
        w_vaddr  = vic_addr[i];
        w_vdata  = vic_data[i];
        w_vdirty = vic_dirty[i];
      end
    end
  end

  always_comb begin
    own_hit  = 1'b0;
    own_data = '0;
    for (int i = 0; i < N; i++) begin
      if (snp_dirty[i] && !src_oh[i]) begin
        own_hit  = 1'b1;
        own_data = own_data | snp_data[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= BS_IDLE;
      src_oh <= '0;
      cmd    <= BC_RD;
      addr   <= '0;
      v_addr <= '0;
      v_data <= '0;
    end else begin
      case (st)
        BS_IDLE: if (|gnt) begin
          src_oh <= gnt;
          cmd    <= w_cmd;
          addr   <= w_addr;
          v_addr <= w_vaddr;
          v_data <= w_vdata;
          st     <= w_vdirty ? BS_WB : BS_XFER;
        end
        BS_WB:   st <= BS_XFER;
        BS_XFER: st <= (!own_hit && cmd == BC_RD) ? BS_WAIT : BS_IDLE;
        default: st <= BS_IDLE;
      endcase
    end
  end

  assign idle      = (st == BS_IDLE);
  assign done      = ((st == BS_XFER) && (own_hit || cmd != BC_RD)) || (st == BS_WAIT);
  assign fill      = (st == BS_WAIT) ? mem_rdata : own_data;
  assign mem_wr_en = (st == BS_WB) || ((st == BS_XFER) && own_hit);
  assign mem_rd_en = (st == BS_XFER) && !own_hit && (cmd == BC_RD);
  assign mem_addr  = (st == BS_WB) ? v_addr : addr;
  assign mem_wdata = (st == BS_WB) ? v_data : own_data;
endmodule

// File: rtl/coh_snoop_fabric.sv
`timescale 1ns/1ps
module coh_snoop_fabric
  import coh_pkg::*;
#(
  parameter int NCORE = 3,
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int IDXW  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCORE-1:0]    core_req_valid,
  output logic [NCORE-1:0]    core_req_ready,
  input  logic [NCORE-1:0]    core_req_write,
  input  logic [NCORE*AW-1:0] core_req_addr,
  input  logic [NCORE*DW-1:0] core_req_wdata,
  output logic [NCORE*DW-1:0] core_rsp_rdata,
  output logic                mem_rd_en,
  output logic                mem_wr_en,
  output logic [AW-1:0]       mem_addr,
  output logic [DW-1:0]       mem_wdata,
  input  logic [DW-1:0]       mem_rdata
);
  logic [NCORE-1:0] bus_req_vec, vic_dirty_vec, snp_dirty_vec, arb_gnt, src_oh;
  bus_cmd_e         req_cmd  [NCORE];
  logic [AW-1:0]    vic_addr [NCORE];
  logic [DW-1:0]    vic_data [NCORE];
  logic [DW-1:0]    snp_data [NCORE];
  logic [AW-1:0]    c_addr   [NCORE];

  logic          bus_idle, bus_done;
  bus_cmd_e      bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] fill_data;

  for (genvar g = 0; g < NCORE; g++) begin : g_core
    assign c_addr[g] = core_req_addr[g*AW +: AW];
    coh_cache #(.AW(AW), .DW(DW), .IDXW(IDXW)) u_cache (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (core_req_valid[g]),
      .req_write   (core_req_write[g]),
      .req_addr    (c_addr[g]),
      .req_wdata   (core_req_wdata[g*DW +: DW]),
      .req_ready   (core_req_ready[g]),
      .rsp_rdata   (core_rsp_rdata[g*DW +: DW]),
      .bus_req     (bus_req_vec[g]),
      .bus_req_cmd (req_cmd[g]),
      .vic_dirty   (vic_dirty_vec[g]),
      .vic_addr    (vic_addr[g]),
      .vic_data    (vic_data[g]),
      .bus_done    (bus_done),
      .bus_src     (src_oh[g]),
      .bus_cmd     (bus_cmd),
      .bus_addr    (bus_addr),
      .fill_data   (fill_data),
      .snp_dirty   (snp_dirty_vec[g]),
      .snp_data    (snp_data[g])
    );
  end

  coh_rr_arb #(.N(NCORE)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (bus_idle),
    .req   (bus_req_vec),
    .gnt   (arb_gnt)
  );

  coh_bus_ctrl #(.N(NCORE), .AW(AW), .DW(DW)) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .gnt       (arb_gnt),
    .req_cmd   (req_cmd),
    .req_addr  (c_addr),
    .vic_dirty (vic_dirty_vec),
    .vic_addr  (vic_addr),
    .vic_data  (vic_data),
    .snp_dirty (snp_dirty_vec),
    .snp_data  (snp_data),
    .idle      (bus_idle),
    .done      (bus_done),
    .src_oh    (src_oh),
    .cmd       (bus_cmd),
    .addr      (bus_addr),
    .fill      (fill_data),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );
endmodule

// File: rtl/coh_snoop_checker.sv
`timescale 1ns/1ps
module coh_snoop_checker #(
  parameter int NCORE = 3,
  parameter int AW    = 8,
  parameter int DW    = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NCORE-1:0]    req_valid,
  input logic [NCORE-1:0]    req_ready,
  input logic [NCORE-1:0]    req_write,
  input logic [NCORE*AW-1:0] req_addr,
  input logic [NCORE*DW-1:0] req_wdata,
  input logic                mem_rd_en,
  input logic                mem_wr_en,
  input logic [NCORE-1:0]    gnt,
  input logic                bus_idle,
  input logic                bus_done,
  input logic [1:0]          done_cmd,
  input logic [NCORE-1:0]    snp_dirty
);
  for (genvar i = 0; i < NCORE; i++) begin : g_port
    a_r10_ready_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready[i] |-> req_valid[i]);
    a_r10_request_held: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[i] && !req_ready[i]) |=> (req_valid[i] && $stable(req_write[i]) &&
        $stable(req_addr[i*AW +: AW]) && $stable(req_wdata[i*DW +: DW])));
  end

  a_r8_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(snp_dirty));
  a_r9_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  a_r9_grant_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt) |-> bus_idle);
  a_r11_mem_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));
  a_r3_upgrade_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_done && done_cmd == 2'b10) |-> (!mem_rd_en && !mem_wr_en));
  a_r2_single_completion: assert property (@(posedge clk) disable iff (!rst_n)
    bus_done |-> ($countones(req_ready) <= 1));
endmodule

bind coh_snoop_fabric coh_snoop_checker #(.NCORE(NCORE), .AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (core_req_valid),
  .req_ready (core_req_ready),
  .req_write (core_req_write),
  .req_addr  (core_req_addr),
  .req_wdata (core_req_wdata),
  .mem_rd_en (mem_rd_en),
  .mem_wr_en (mem_wr_en),
  .gnt       (arb_gnt),
  .bus_idle  (bus_idle),
  .bus_done  (bus_done),
  .done_cmd  (bus_cmd),
  .snp_dirty (snp_dirty_vec)
);

// File: tb/coh_snoop_fabric_test.sv
`timescale 1ns/1ps
module coh_snoop_fabric_test;
  localparam int NC = 3;
  localparam int AW = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic [NC-1:0]    v, rdy, wr;
  logic [NC*AW-1:0] a;
  logic [NC*DW-1:0] wd, rd;
  logic             mem_rd_en, mem_wr_en;
  logic [AW-1:0]    mem_addr;
  logic [DW-1:0]    mem_wdata, mem_rdata;

  logic          b_valid [NC];
  logic          b_write [NC];
  logic [AW-1:0] b_addr  [NC];
  logic [DW-1:0] b_wdata [NC];

  always_comb begin
    for (int c = 0; c < NC; c++) begin
      v[c]            = b_valid[c];
      wr[c]           = b_write[c];
      a[c*AW +: AW]   = b_addr[c];
      wd[c*DW +: DW]  = b_wdata[c];
    end
  end

  coh_snoop_fabric #(.NCORE(NC), .AW(AW), .DW(DW), .IDXW(2)) uut (
    .clk(clk), .rst_n(rst_n),
    .core_req_valid(v), .core_req_ready(rdy), .core_req_write(wr),
    .core_req_addr(a), .core_req_wdata(wd), .core_rsp_rdata(rd),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [DW-1:0] init_val(input int ad);
    return DW'(ad * 37 + 5);
  endfunction

  // memory model: one-cycle read latency
  logic [DW-1:0] bmem [256];
  initial begin
    for (int i = 0; i < 256; i++) bmem[i] = init_val(i);
    mem_rdata = '0;
    forever begin
      @(posedge clk);
      if (mem_rd_en) mem_rdata <= bmem[mem_addr];
      if (mem_wr_en) bmem[mem_addr] = mem_wdata;
    end
  end

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] gold [256];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic op(input int c, input bit w, input logic [AW-1:0] ad, input logic [DW-1:0] d,
                    output logic [DW-1:0] q, output int lat, output bit saw_rd);
    b_valid[c] = 1'b1; b_write[c] = w; b_addr[c] = ad; b_wdata[c] = d;
    lat = 0; saw_rd = 1'b0; q = '0;
    forever begin
      @(negedge clk);
      if (mem_rd_en) saw_rd = 1'b1;
      if (rdy[c]) begin
        q = rd[c*DW +: DW];
        break;
      end
      lat++;
    end
    @(posedge clk); #1;
    b_valid[c] = 1'b0;
  endtask

  task automatic run_core(input int c, input int nops);
    logic [DW-1:0] q;
    int lat;
    bit s;
    for (int n = 0; n < nops; n++) begin
      int gap = int'($urandom % 3);
      if (gap > 0) begin
        repeat (gap) @(posedge clk);
        #1;
      end
      op(c, bit'($urandom % 2), AW'((($urandom % 3) << 2) | ($urandom % 4)),
         DW'($urandom), q, lat, s);
    end
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail + 1);
    $finish;
  end

  initial begin
    logic [DW-1:0] q, q0, q1, q2;
    int lat, l0, l1, l2;
    bit s, s0, s1, s2;
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) gold[i] = init_val(i);
    for (int c = 0; c < NC; c++) begin
      b_valid[c] = 0; b_write[c] = 0; b_addr[c] = '0; b_wdata[c] = '0;
    end
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rdy == '0 && !mem_rd_en && !mem_wr_en, "R12 reset quiet", int'(rdy), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;

    fork
      // golden monitor (R1)
      forever begin
        @(negedge clk);
        for (int c = 0; c < NC; c++) begin
          if (b_valid[c] && rdy[c]) begin
            if (b_write[c]) gold[b_addr[c]] = b_wdata[c];
            else chk(rd[c*DW +: DW] == gold[b_addr[c]], "R1 load value",
                     int'(rd[c*DW +: DW]), int'(gold[b_addr[c]]));
          end
        end
      end
      begin
        // R12: first access misses to memory
        op(0, 0, 8'h05, '0, q, lat, s);
        chk(lat > 0 && s, "R12 first load goes to memory", lat, 1);
        chk(q == init_val(5), "R12 first load data", int'(q), int'(init_val(5)));
        // R2: read hit
        op(0, 0, 8'h05, '0, q, lat, s);
        chk(lat == 0 && !s, "R2 shared read hit", lat, 0);
        // R3: upgrade
        op(0, 1, 8'h05, 16'h1111, q, lat, s);
        chk(lat > 0, "R3 upgrade uses bus", lat, 1);
        chk(!s, "R3 upgrade no memory read", int'(s), 0);
        // R2: write hit on modified
        op(0, 1, 8'h05, 16'h2222, q, lat, s);
        chk(lat == 0, "R2 modified write hit", lat, 0);
        // R4: owner supplies
        op(1, 0, 8'h05, '0, q, lat, s);
        chk(q == 16'h2222, "R4 owner data", int'(q), 16'h2222);
        chk(!s, "R4 no memory read", int'(s), 0);
        chk(bmem[5] == 16'h2222, "R4 written back", int'(bmem[5]), 16'h2222);
        // R5: former owner shared
        op(0, 0, 8'h05, '0, q, lat, s);
        chk(lat == 0, "R5 former owner hits", lat, 0);
        op(1, 0, 8'h05, '0, q, lat, s);
        chk(lat == 0, "R5 reader hits", lat, 0);
        // R6: invalidate peers
        op(2, 1, 8'h05, 16'h3333, q, lat, s);
        chk(lat > 0, "R6 store by third core uses bus", lat, 1);
        op(0, 0, 8'h05, '0, q, lat, s);
        chk(lat > 0, "R6 invalidated copy misses", lat, 1);
        chk(q == 16'h3333, "R6 new value", int'(q), 16'h3333);
        chk(bmem[5] == 16'h3333, "R4 supply writes memory", int'(bmem[5]), 16'h3333);
        // R7: dirty eviction
        op(2, 1, 8'h05, 16'h4444, q, lat, s);
        op(2, 0, 8'h09, '0, q, lat, s);
        chk(bmem[5] == 16'h4444, "R7 victim written back", int'(bmem[5]), 16'h4444);
        chk(q == init_val(9), "R7 fill after eviction", int'(q), int'(init_val(9)));
        // R9: simultaneous misses
        fork
          op(0, 0, 8'h0C, '0, q0, l0, s0);
          op(1, 0, 8'h0E, '0, q1, l1, s1);
          op(2, 0, 8'h0F, '0, q2, l2, s2);
        join
        chk(l0 != l1 && l1 != l2 && l0 != l2, "R9 distinct completions", l0 * 100 + l1 * 10 + l2, 0);
        chk(q0 == init_val(12) && q1 == init_val(14) && q2 == init_val(15),
            "R9 contended data", int'(q0), int'(init_val(12)));
        // random phase (R1, R8, R10, R11 via monitor and checker)
        for (int c = 0; c < NC; c++) begin
          automatic int cc = c;
          fork
            run_core(cc, 300);
          join_none
        end
        wait fork;
        repeat (4) @(posedge clk);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule